// File: doc/BRIEF.md
# Dual-Channel Bus Breakpoint Comparator

This block watches two bus monitor ports, a local bus and an internal bus, and raises a break request toward the processor when a bus cycle meets a programmed condition. There are two independent channels. Each channel compares the cycle address under a mask and the address-space ID. It also checks a condition word that selects the bus, the kind of cycle (instruction fetch or data access) and the direction (read or write). Channel B also compares the data value under a data mask.

Each channel keeps one sticky match flag per bus. Software reads the flags and clears them by writing zero. Matches from both channels in the same cycle fold into a single request pulse, and every flag that matched is still set. On the internal bus, instruction fetches are longword transfers, so their address is rounded down to a 4-byte boundary before it is compared.

Top module: `bus_break_unit`

## Requirements
- R1: After reset the break request and all four flags are 0, and every register reads as 0. A zero condition word means no bus cycle causes a break.
- R2: The condition word (register 3 for channel A, 7 for B) has three 2-bit groups: bus in bits [1:0] (01 local, 10 internal, 11 either), kind in [3:2] (01 fetch, 10 data, 11 either) and direction in [5:4] (01 read, 10 write, 11 either). A cycle matches only if it fits all three groups, so a group of 00 disables the channel.
- R3: An address matches when it equals the channel address (register 0 or 4) on every bit whose mask bit (register 1 or 5) is 0. The ASID must also equal the channel ASID (register 2 or 6).
- R4: Channel B also requires the data to equal register 8 on every bit whose mask bit in register 9 is 0. Channel A ignores the data.
- R5: For an instruction fetch on the internal bus, address bits [1:0] are treated as 0 in the comparison. On the local bus the address is compared unchanged.
- R6: Only cycles with valid high are evaluated. A match raises brk_req_o for exactly one clock, on the clock edge that ends the matching cycle.
- R7: A match sets that channel's flag for the bus it was seen on, on the same edge as the request. Bit 0 of each flag output is channel A and bit 1 is channel B.
- R8: Flags stay set. A write to register 10 clears each flag whose bit in wdata[3:0] is 0 and leaves alone each flag whose bit is 1. The bit order is {ib_b, ib_a, lb_b, lb_a}.
- R9: When both channels match in one cycle, one request pulse is issued and both flags are set.
- R10: A register write takes effect at the next clock. A channel does not compare during a cycle in which its condition word is being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| lb_valid_i | input | 1 | Local bus cycle valid |
| lb_addr_i | input | 32 | Local bus address |
| lb_data_i | input | 32 | Local bus data |
| lb_asid_i | input | 8 | Local bus address-space ID |
| lb_fetch_i | input | 1 | Local bus cycle is an instruction fetch |
| lb_write_i | input | 1 | Local bus cycle is a write |
| ib_valid_i | input | 1 | Internal bus cycle valid |
| ib_addr_i | input | 32 | Internal bus physical address |
| ib_data_i | input | 32 | Internal bus data |
| ib_asid_i | input | 8 | Internal bus address-space ID |
| ib_fetch_i | input | 1 | Internal bus cycle is an instruction fetch |
| ib_write_i | input | 1 | Internal bus cycle is a write |
| brk_req_o | output | 1 | Break request pulse |
| flag_lb_o | output | 2 | Local bus match flags, bit 0 = A, bit 1 = B |
| flag_ib_o | output | 2 | Internal bus match flags, bit 0 = A, bit 1 = B |

## Verification
A corrupted address, mask, ASID or condition register shows up at the ports on the first probe cycle that lands on an affected bit. That cycle either gives a request and flag that should not be there, or it misses one, one clock after valid. A flag register that loses its sticky state, or that ignores the clear write, is exposed by the next idle cycle or the cycle after that write, because the flags are outputs directly. The probes sit on the edges of each field: one unmasked bit off, the ASID off by one, fetch addresses off longword alignment, and each 2-bit group set to one choice only. These cases separate the group decoding, the rounding and the masking from one another.

// File: rtl/bbu_pkg.sv
package bbu_pkg;
  parameter int XLEN   = 32;
  parameter int ASID_W = 8;
  parameter int NCH    = 2;
  parameter int NBUS   = 2;   // 0 = local, 1 = internal
  parameter int DATA_CH = 1;  // channel with data compare
  parameter int RA_W   = 4;

  localparam logic [RA_W-1:0] OFS_ADDR  = 4'd0;
  localparam logic [RA_W-1:0] OFS_MASK  = 4'd1;
  localparam logic [RA_W-1:0] OFS_ASID  = 4'd2;
  localparam logic [RA_W-1:0] OFS_COND  = 4'd3;
  localparam logic [RA_W-1:0] REG_DATA  = 4'd8;
  localparam logic [RA_W-1:0] REG_DMASK = 4'd9;
  localparam logic [RA_W-1:0] REG_FLAGS = 4'd10;

  typedef struct packed {
    logic [1:0] dir;   // [0] read, [1] write
    logic [1:0] kind;  // [0] fetch, [1] data
    logic [1:0] bus;   // [0] local, [1] internal
  } cond_t;

  typedef struct packed {
    logic              valid;
    logic [XLEN-1:0]   addr;
    logic [XLEN-1:0]   data;
    logic [ASID_W-1:0] asid;
    logic              fetch;
    logic              write;
  } cyc_t;
endpackage

// File: rtl/bbu_regs.sv
module bbu_regs
  import bbu_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [RA_W-1:0]       addr_i,
  input  logic [XLEN-1:0]       wdata_i,
  output logic [XLEN-1:0]       ch_addr_o [NCH],
  output logic [XLEN-1:0]       ch_mask_o [NCH],
  output logic [ASID_W-1:0]     ch_asid_o [NCH],
  output cond_t                 ch_cond_o [NCH],
  output logic [NCH-1:0]        cond_wr_o,
  output logic [XLEN-1:0]       data_o,
  output logic [XLEN-1:0]       dmask_o
);
  localparam int CW = $bits(cond_t);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [RA_W-1:0] BASE = RA_W'(c * 4);
    assign cond_wr_o[c] = we_i && addr_i == (BASE | OFS_COND);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ch_addr_o[c] <= '0;
        ch_mask_o[c] <= '0;
        ch_asid_o[c] <= '0;
        ch_cond_o[c] <= '0;
      end else if (we_i) begin
        if (addr_i == (BASE | OFS_ADDR)) ch_addr_o[c] <= wdata_i;
        if (addr_i == (BASE | OFS_MASK)) ch_mask_o[c] <= wdata_i;
        if (addr_i == (BASE | OFS_ASID)) ch_asid_o[c] <= wdata_i[ASID_W-1:0];
        if (cond_wr_o[c])                ch_cond_o[c] <= cond_t'(wdata_i[CW-1:0]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      dmask_o <= '0;
    end else if (we_i) begin
      if (addr_i == REG_DATA)  data_o  <= wdata_i;
      if (addr_i == REG_DMASK) dmask_o <= wdata_i;
    end
  end
endmodule

// File: rtl/bbu_chan_cmp.sv
module bbu_chan_cmp
  import bbu_pkg::*;
#(
  parameter bit IS_IB    = 1'b0,
  parameter bit HAS_DATA = 1'b0
) (
  input  cyc_t              cyc_i,
  input  logic [XLEN-1:0]   bar_i,
  input  logic [XLEN-1:0]   bam_i,
  input  logic [ASID_W-1:0] asid_i,
  input  cond_t             cond_i,
  input  logic [XLEN-1:0]   bdr_i,
  input  logic [XLEN-1:0]   bdm_i,
  input  logic              hold_i,
  output logic              hit_o
);
  logic [XLEN-1:0] eff_addr;
  logic bus_ok, kind_ok, dir_ok, addr_ok, asid_ok, data_ok;

  // internal-bus fetches are longword transfers
  assign eff_addr = (IS_IB && cyc_i.fetch) ? {cyc_i.addr[XLEN-1:2], 2'b00} : cyc_i.addr;

  assign bus_ok  = IS_IB ? cond_i.bus[1] : cond_i.bus[0];
  assign kind_ok = cyc_i.fetch ? cond_i.kind[0] : cond_i.kind[1];
  assign dir_ok  = cyc_i.write ? cond_i.dir[1]  : cond_i.dir[0];
  assign addr_ok = ((eff_addr ^ bar_i) & ~bam_i) == '0;
  assign asid_ok = cyc_i.asid == asid_i;
  assign data_ok = HAS_DATA ? (((cyc_i.data ^ bdr_i) & ~bdm_i) == '0) : 1'b1;

  assign hit_o = cyc_i.valid && !hold_i && bus_ok && kind_ok && dir_ok
              && addr_ok && asid_ok && data_ok;
endmodule

// File: rtl/bbu_flags.sv
module bbu_flags
  import bbu_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCH-1:0]        hit_i [NBUS],
  input  logic                  clr_we_i,
  input  logic [NBUS*NCH-1:0]   keep_i,
  output logic [NCH-1:0]        flag_o [NBUS],
  output logic                  req_o
);
  logic any_hit;

  always_comb begin
    any_hit = 1'b0;
    for (int b = 0; b < NBUS; b++) any_hit = any_hit | (|hit_i[b]);
  end

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[b] <= '0;
      else flag_o[b] <= (clr_we_i ? (flag_o[b] & keep_i[b*NCH +: NCH]) : flag_o[b])
                        | hit_i[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= any_hit;
  end
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [XLEN-1:0]   reg_wdata_i,
  input  logic              lb_valid_i,
  input  logic [XLEN-1:0]   lb_addr_i,
  input  logic [XLEN-1:0]   lb_data_i,
  input  logic [ASID_W-1:0] lb_asid_i,
  input  logic              lb_fetch_i,
  input  logic              lb_write_i,
  input  logic              ib_valid_i,
  input  logic [XLEN-1:0]   ib_addr_i,
  input  logic [XLEN-1:0]   ib_data_i,
  input  logic [ASID_W-1:0] ib_asid_i,
  input  logic              ib_fetch_i,
  input  logic              ib_write_i,
  output logic              brk_req_o,
  output logic [NCH-1:0]    flag_lb_o,
  output logic [NCH-1:0]    flag_ib_o
);
  logic [XLEN-1:0]   ch_addr [NCH];
  logic [XLEN-1:0]   ch_mask [NCH];
  logic [ASID_W-1:0] ch_asid [NCH];
  cond_t             ch_cond [NCH];
  logic [NCH-1:0]    cond_wr;
  logic [XLEN-1:0]   bdr, bdm;
  cyc_t              cyc [NBUS];
  logic [NCH-1:0]    hit [NBUS];
  logic [NCH-1:0]    flag [NBUS];

  assign cyc[0] = '{valid: lb_valid_i, addr: lb_addr_i, data: lb_data_i,
                    asid: lb_asid_i, fetch: lb_fetch_i, write: lb_write_i};
  assign cyc[1] = '{valid: ib_valid_i, addr: ib_addr_i, data: ib_data_i,
                    asid: ib_asid_i, fetch: ib_fetch_i, write: ib_write_i};

  bbu_regs u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .ch_addr_o (ch_addr),
    .ch_mask_o (ch_mask),
    .ch_asid_o (ch_asid),
    .ch_cond_o (ch_cond),
    .cond_wr_o (cond_wr),
    .data_o    (bdr),
    .dmask_o   (bdm)
  );

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      bbu_chan_cmp #(
        .IS_IB    (b == 1),
        .HAS_DATA (c == DATA_CH)
      ) u_cmp (
        .cyc_i  (cyc[b]),
        .bar_i  (ch_addr[c]),
        .bam_i  (ch_mask[c]),
        .asid_i (ch_asid[c]),
        .cond_i (ch_cond[c]),
        .bdr_i  (bdr),
        .bdm_i  (bdm),
        .hold_i (cond_wr[c]),
        .hit_o  (hit[b][c])
      );
    end
  end

  bbu_flags u_flags (
    .clk_i, .rst_ni,
    .hit_i    (hit),
    .clr_we_i (reg_we_i && reg_addr_i == REG_FLAGS),
    .keep_i   (reg_wdata_i[NBUS*NCH-1:0]),
    .flag_o   (flag),
    .req_o    (brk_req_o)
  );

  assign flag_lb_o = flag[0];
  assign flag_ib_o = flag[1];
endmodule

// File: rtl/bbu_checker.sv
module bbu_checker
  import bbu_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reg_we_i,
  input logic [RA_W-1:0] reg_addr_i,
  input logic [XLEN-1:0] reg_wdata_i,
  input logic            lb_valid_i,
  input logic            ib_valid_i,
  input logic            brk_req_o,
  input logic [NCH-1:0]  flag_lb_o,
  input logic [NCH-1:0]  flag_ib_o
);
  logic [2*NCH-1:0] fl;
  assign fl = {flag_ib_o, flag_lb_o};

  AST_REQ_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> $past(lb_valid_i || ib_valid_i)); // R6

  AST_LB_FLAG_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag_lb_o & ~$past(flag_lb_o))) |-> $past(lb_valid_i)); // R7

  AST_IB_FLAG_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag_ib_o & ~$past(flag_ib_o))) |-> $past(ib_valid_i)); // R7

  AST_FLAG_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(fl & ~$past(fl))) |-> brk_req_o); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(fl) & ~fl)) |-> $past(reg_we_i && reg_addr_i == REG_FLAGS)); // R8

  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reg_we_i && reg_addr_i == REG_FLAGS && !lb_valid_i && !ib_valid_i)
    |-> (fl & ~$past(reg_wdata_i[2*NCH-1:0])) == '0); // R8
endmodule

bind bus_break_unit bbu_checker u_bbu_checker (.*);

// File: tb/bus_break_unit_tb_top.sv
module bus_break_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        lb_valid_i = 1'b0, ib_valid_i = 1'b0;
  logic [31:0] lb_addr_i = '0, lb_data_i = '0, ib_addr_i = '0, ib_data_i = '0;
  logic [7:0]  lb_asid_i = '0, ib_asid_i = '0;
  logic        lb_fetch_i = 1'b0, lb_write_i = 1'b0, ib_fetch_i = 1'b0, ib_write_i = 1'b0;
  logic        brk_req_o;
  logic [1:0]  flag_lb_o, flag_ib_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [4:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_break_unit dut_i (.*);

  // monitor: pops expected {req, ib_b, ib_a, lb_b, lb_a}
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      logic [4:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {brk_req_o, flag_ib_o, flag_lb_o};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual req=%b flags=%b expected req=%b flags=%b",
                 t, a[4], a[3:0], e[4], e[3:0]);
      end
    end
  end

  task automatic idle();
    reg_we_i = 1'b0; lb_valid_i = 1'b0; ib_valid_i = 1'b0;
  endtask

  task automatic set_reg(input logic [3:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
  endtask

  task automatic lb(input logic v, input logic [31:0] a, input logic [31:0] d,
                    input logic [7:0] s, input logic f, input logic w);
    lb_valid_i = v; lb_addr_i = a; lb_data_i = d; lb_asid_i = s;
    lb_fetch_i = f; lb_write_i = w;
  endtask

  task automatic ib(input logic v, input logic [31:0] a, input logic [31:0] d,
                    input logic [7:0] s, input logic f, input logic w);
    ib_valid_i = v; ib_addr_i = a; ib_data_i = d; ib_asid_i = s;
    ib_fetch_i = f; ib_write_i = w;
  endtask

  // driver: one clock, push the expected result of that clock
  task automatic tick(input logic r, input logic [3:0] f, input string t);
    @(posedge clk_i);
    exp_q.push_back({r, f});
    tag_q.push_back(t);
    @(negedge clk_i);
    idle();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    set_reg(a, d);
    @(posedge clk_i);
    @(negedge clk_i);
    idle();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    tick(0, 4'b0000, "R1 reset idle");
    lb(1, 32'h0, 32'h0, 8'h0, 0, 0);
    tick(0, 4'b0000, "R1 zero condition no break");

    wr(4'd0, 32'h1000); wr(4'd1, 32'h000F); wr(4'd2, 32'd5);
    wr(4'd3, 32'h1D);   // local, either kind, read
    lb(1, 32'h100A, 32'h0, 8'd5, 0, 0);
    tick(1, 4'b0001, "R3 masked address match");
    tick(0, 4'b0001, "R6 one-cycle pulse");
    lb(1, 32'h100A, 32'h0, 8'd5, 0, 1);
    tick(0, 4'b0001, "R2 direction group");
    lb(1, 32'h1010, 32'h0, 8'd5, 0, 0);
    tick(0, 4'b0001, "R3 unmasked bit differs");
    lb(1, 32'h100A, 32'h0, 8'd6, 0, 0);
    tick(0, 4'b0001, "R3 asid mismatch");
    ib(1, 32'h100A, 32'h0, 8'd5, 0, 0);
    tick(0, 4'b0001, "R2 bus group");
    lb(0, 32'h100A, 32'h0, 8'd5, 0, 0);
    tick(0, 4'b0001, "R6 invalid cycle ignored");
    set_reg(4'd10, 32'hF);
    tick(0, 4'b0001, "R8 writing one keeps flag");
    set_reg(4'd10, 32'h0);
    tick(0, 4'b0000, "R8 writing zero clears flag");
    lb(1, 32'h1003, 32'h0, 8'd5, 1, 0);
    tick(1, 4'b0001, "R7 flag set again after clear");
    wr(4'd10, 32'h0);

    wr(4'd0, 32'h2000); wr(4'd1, 32'h0);
    wr(4'd3, 32'h36);   // internal, fetch, either direction
    ib(1, 32'h2003, 32'h0, 8'd5, 1, 0);
    tick(1, 4'b0100, "R5 internal fetch address rounded");
    ib(1, 32'h2000, 32'h0, 8'd5, 0, 0);
    tick(0, 4'b0100, "R2 kind group");
    wr(4'd3, 32'h37);   // either bus
    lb(1, 32'h2003, 32'h0, 8'd5, 1, 0);
    tick(0, 4'b0100, "R5 local fetch not rounded");
    lb(1, 32'h2000, 32'h0, 8'd5, 1, 0);
    tick(1, 4'b0101, "R7 local flag separate from internal");
    wr(4'd10, 32'h0);

    wr(4'd4, 32'h3000); wr(4'd5, 32'h0); wr(4'd6, 32'd5);
    wr(4'd8, 32'hAB00); wr(4'd9, 32'h00FF); wr(4'd7, 32'h3F);
    lb(1, 32'h3000, 32'hAB55, 8'd5, 0, 1);
    tick(1, 4'b0010, "R4 data match under mask");
    lb(1, 32'h3000, 32'hAC55, 8'd5, 0, 1);
    tick(0, 4'b0010, "R4 data mismatch");
    wr(4'd10, 32'h0);

    wr(4'd0, 32'h3000); wr(4'd3, 32'h3F);
    lb(1, 32'h3000, 32'h1234, 8'd5, 0, 1);
    tick(1, 4'b0001, "R4 channel A ignores data");
    wr(4'd10, 32'h0);
    lb(1, 32'h3000, 32'hAB00, 8'd5, 0, 1);
    tick(1, 4'b0011, "R9 both channels one request");
    tick(0, 4'b0011, "R9 single pulse");
    lb(1, 32'h3000, 32'hAB00, 8'd5, 0, 1);
    ib(1, 32'h3000, 32'hAB00, 8'd5, 0, 1);
    tick(1, 4'b1111, "R9 both channels on both buses");
    wr(4'd10, 32'h0);

    set_reg(4'd3, 32'h3F);
    lb(1, 32'h3000, 32'h1234, 8'd5, 0, 1);
    tick(0, 4'b0000, "R10 channel A held during condition write");
    set_reg(4'd7, 32'h3F);
    lb(1, 32'h3000, 32'hAB00, 8'd5, 0, 1);
    tick(1, 4'b0001, "R10 channel B held, A still fires");
    wr(4'd10, 32'h0);
    set_reg(4'd3, 32'h0F);
    tick(0, 4'b0000, "R10 write with no bus cycle");
    lb(1, 32'h3000, 32'h1234, 8'd5, 0, 1);
    tick(0, 4'b0000, "R2 zero direction group disables");

    @(negedge clk_i);
    #1;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule